// File: doc/BRIEF.md
# UART Receive Path with Address-Filtered Attention Mode

This block turns an asynchronous serial line into parallel characters. It runs on a single system clock and counts a 16x oversampling tick pulse. That tick can come from an internal divider or from an external source, chosen by one select input. A frame-length code sets the frame to seven, eight or nine data bits, or to loopback. In loopback the receiver takes its serial input from the local transmitter output and uses nine-bit framing. The block qualifies each start bit at mid-bit. It samples every data bit at its centre, least significant bit first, then checks the optional parity bit and the stop bit. A finished character goes into a one-byte holding buffer.

Software sees a buffer-full flag, a status byte, a global error flag and an interrupt request. The status byte holds sticky parity, framing and overrun flags, the attention-mode bit, the received ninth bit and a line-break status flag. Reading the buffer and reading the status byte are signalled by one-cycle strobes. For multidrop networks, an attention mode accepts only nine-bit characters whose ninth bit is 1, treating them as address characters. The mode clears itself on the first such character.

Top module: `uart_rx_attn`

## Requirements
- R1: After reset, buf_full_o, err_o and irq_o are 0, and status_o and rx_data_o are all zero.
- R2: buf_full_o rises once a completed character has been written into the buffer. A one-cycle buf_rd_i pulse clears it.
- R3: frame_mode_i selects the frame length: 2'b00 gives eight data bits, 2'b01 gives seven and 2'b10 gives nine. Data bits arrive least significant first. In seven-bit frames rx_data_o[7] reads 0.
- R4: Parity applies only to seven- and eight-bit frames with par_en_i at 1. par_sel_i 2'b00 means odd, 2'b01 even, 2'b10 a parity bit fixed at 1 and 2'b11 a parity bit fixed at 0. A mismatch sets status_o[0].
- R5: status_o[0] (parity), status_o[1] (framing) and status_o[2] (overrun) are sticky. A stat_rd_i pulse clears all three. A stat_wr_i write leaves them unchanged whatever stat_wdata_i holds.
- R6: If a character completes while buf_full_o is still 1 and no buffer read comes in the same cycle, status_o[2] sets and rx_data_o keeps the older character.
- R7: A stop bit sampled as 0 sets status_o[1] and the receiving flag status_o[5]. status_o[5] clears once the serial input is high again.
- R8: err_o is 1 exactly when at least one of status_o[2:0] is 1.
- R9: irq_o equals buf_full_o gated by irq_en_i.
- R10: status_o[3] is the attention bit, loaded from stat_wdata_i[3] on a stat_wr_i pulse. While it is 1 in a nine-bit mode, characters whose ninth bit is 0 are dropped and leave the buffer and buf_full_o untouched. A character whose ninth bit is 1 is accepted and clears status_o[3].
- R11: frame_mode_i 2'b11 receives nine-bit frames from txd_loop_i and ignores rxd_i.
- R12: tick_sel_i at 0 uses tick_int_i as the oversampling tick, and at 1 uses tick_ext_i.
- R13: In nine-bit modes, status_o[4] holds the ninth bit of the last character loaded into the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_int_i | input | 1 | Internal 16x oversampling tick pulse |
| tick_ext_i | input | 1 | External 16x oversampling tick pulse |
| tick_sel_i | input | 1 | Tick source select (0 internal, 1 external) |
| rxd_i | input | 1 | Serial receive line |
| txd_loop_i | input | 1 | Transmitter output used in loopback |
| frame_mode_i | input | 2 | Frame length / loopback code |
| par_en_i | input | 1 | Parity enable |
| par_sel_i | input | 2 | Parity kind |
| irq_en_i | input | 1 | Receive interrupt enable |
| buf_rd_i | input | 1 | Buffer read strobe |
| stat_rd_i | input | 1 | Status read strobe |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 8 | Status write data (only bit 3 used) |
| rx_data_o | output | 8 | Receive buffer contents |
| buf_full_o | output | 1 | Buffer holds an unread character |
| status_o | output | 8 | Status byte |
| err_o | output | 1 | Global error flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench uses the defaults: sixteen ticks per bit, nine-bit maximum frame and a two-stage input synchroniser. With an internal tick every four clocks and an external tick every three, a full nine-bit frame lasts well under a thousand cycles. That makes it cheap to chain back-to-back characters for overrun, break recovery after a framing error, attention filtering and loopback. The differing tick rates show that the select input really changes the bit timing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    FRM_EIGHT = 2'b00,
    FRM_SEVEN = 2'b01,
    FRM_NINE  = 2'b10,
    FRM_LOOP  = 2'b11
  } frame_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_BREAK
  } rx_state_e;

  localparam int unsigned STAT_PE   = 0;
  localparam int unsigned STAT_FE   = 1;
  localparam int unsigned STAT_DOE  = 2;
  localparam int unsigned STAT_ATTN = 3;
  localparam int unsigned STAT_B9   = 4;
  localparam int unsigned STAT_RCV  = 5;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_d = d_i;
    end else begin : g_many
      always_comb sr_d = {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS  = 16,
  parameter int unsigned MAXB = 9,
  localparam int unsigned CW  = $clog2(OVS),
  localparam int unsigned BW  = $clog2(MAXB + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            line_i,
  input  logic [BW-1:0]   nbits_i,
  input  logic            par_on_i,
  input  logic [1:0]      par_sel_i,
  output logic            done_o,
  output logic [MAXB-1:0] data_o,
  output logic            perr_o,
  output logic            ferr_o
);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [BW-1:0]   idx_q, idx_d;
  logic [MAXB-1:0] shf_q, shf_d;
  logic            par_q, par_d;
  logic            done_q, done_d;
  logic            perr_q, perr_d;
  logic            ferr_q, ferr_d;
  logic            par_bad;
  logic            mid_tick;

  assign mid_tick = tick_i && (cnt_q == LAST);

  always_comb begin
    unique case (par_e'(par_sel_i))
      PAR_ODD:   par_bad = ((^shf_q) ^ par_q) == 1'b0;
      PAR_EVEN:  par_bad = ((^shf_q) ^ par_q) == 1'b1;
      PAR_MARK:  par_bad = !par_q;
      default:   par_bad = par_q;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    par_d   = par_q;
    done_d  = 1'b0;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (tick_i && !line_i) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            if (!line_i) begin
              state_d = ST_DATA;
              idx_d   = '0;
              shf_d   = '0;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (mid_tick) begin
          cnt_d = '0;
          if (idx_q < BW'(MAXB)) shf_d[idx_q] = line_i;
          idx_d = idx_q + 1'b1;
          if (idx_q == nbits_i - 1'b1) state_d = par_on_i ? ST_PARITY : ST_STOP;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PARITY: begin
        if (mid_tick) begin
          cnt_d   = '0;
          par_d   = line_i;
          state_d = ST_STOP;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (mid_tick) begin
          cnt_d   = '0;
          done_d  = 1'b1;
          ferr_d  = !line_i;
          perr_d  = par_on_i && par_bad;
          state_d = line_i ? ST_IDLE : ST_BREAK;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_BREAK: begin
        if (line_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      par_q   <= par_d;
      done_q  <= done_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign done_o = done_q;
  assign data_o = shf_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;

  // R7: a character ending on a low stop bit leaves the framer waiting for line recovery
  p_break_after_ferr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ferr_o) |-> (state_q == ST_BREAK || line_i));

  // R3: the data bit index never passes the selected frame length
  p_idx_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (idx_q < nbits_i));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int unsigned MAXB = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            done_i,
  input  logic [MAXB-1:0] data_i,
  input  logic            perr_i,
  input  logic            ferr_i,
  input  logic            nine_i,
  input  logic            seven_i,
  input  logic            line_i,
  input  logic            buf_rd_i,
  input  logic            stat_rd_i,
  input  logic            stat_wr_i,
  input  logic            attn_wr_i,
  input  logic            irq_en_i,
  output logic [7:0]      rx_data_o,
  output logic            buf_full_o,
  output logic [7:0]      status_o,
  output logic            err_o,
  output logic            irq_o
);
  logic [7:0] buf_q, buf_d;
  logic       full_q, full_d;
  logic       pe_q, pe_d, fe_q, fe_d, doe_q, doe_d;
  logic       attn_q, attn_d;
  logic       b9_q, b9_d;
  logic       rcv_q, rcv_d;
  logic       drop, take, load, ovr;

  always_comb begin
    drop = done_i && nine_i && attn_q && !data_i[MAXB-1];
    take = done_i && !drop;
    ovr  = take && full_q && !buf_rd_i;
    load = take && !ovr;

    buf_d  = buf_q;
    b9_d   = b9_q;
    if (load) begin
      buf_d = seven_i ? {1'b0, data_i[6:0]} : data_i[7:0];
      b9_d  = nine_i && data_i[MAXB-1];
    end
    full_d = load ? 1'b1 : (buf_rd_i ? 1'b0 : full_q);

    pe_d  = (take && perr_i) || (pe_q  && !stat_rd_i);
    fe_d  = (take && ferr_i) || (fe_q  && !stat_rd_i);
    doe_d = ovr              || (doe_q && !stat_rd_i);

    attn_d = attn_q;
    if (stat_wr_i)                               attn_d = attn_wr_i;
    else if (take && nine_i && data_i[MAXB-1])   attn_d = 1'b0;

    rcv_d = (done_i && ferr_i) ? 1'b1 : (line_i ? 1'b0 : rcv_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      doe_q  <= 1'b0;
      attn_q <= 1'b0;
      b9_q   <= 1'b0;
      rcv_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      doe_q  <= doe_d;
      attn_q <= attn_d;
      b9_q   <= b9_d;
      rcv_q  <= rcv_d;
    end
  end

  always_comb begin
    status_o            = '0;
    status_o[STAT_PE]   = pe_q;
    status_o[STAT_FE]   = fe_q;
    status_o[STAT_DOE]  = doe_q;
    status_o[STAT_ATTN] = attn_q;
    status_o[STAT_B9]   = b9_q;
    status_o[STAT_RCV]  = rcv_q;
  end

  assign rx_data_o  = buf_q;
  assign buf_full_o = full_q;
  assign err_o      = pe_q | fe_q | doe_q;
  assign irq_o      = irq_en_i & full_q;

  // R6: an overrun keeps the older character and raises the overrun flag
  p_overrun_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && take && !buf_rd_i) |=> ($stable(buf_q) && doe_q));

  // R5: a status read with no new character leaves all sticky errors clear
  p_stat_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !done_i) |=> (!pe_q && !fe_q && !doe_q));

  // R2: a buffer read with no new character empties the buffer
  p_read_empties_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_rd_i && !done_i) |=> !full_q);

  // R10: an address character ends attention mode
  p_attn_ends_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attn_q && done_i && nine_i && data_i[MAXB-1] && !stat_wr_i) |=> !attn_q);

  // R10: a dropped character touches neither buffer nor full flag
  p_drop_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop && !buf_rd_i) |=> ($stable(buf_q) && $stable(full_q)));
endmodule

// File: rtl/uart_rx_attn.sv
module uart_rx_attn
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned MAXB        = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_int_i,
  input  logic       tick_ext_i,
  input  logic       tick_sel_i,
  input  logic       rxd_i,
  input  logic       txd_loop_i,
  input  logic [1:0] frame_mode_i,
  input  logic       par_en_i,
  input  logic [1:0] par_sel_i,
  input  logic       irq_en_i,
  input  logic       buf_rd_i,
  input  logic       stat_rd_i,
  input  logic       stat_wr_i,
  input  logic [7:0] stat_wdata_i,
  output logic [7:0] rx_data_o,
  output logic       buf_full_o,
  output logic [7:0] status_o,
  output logic       err_o,
  output logic       irq_o
);
  localparam int unsigned BW = $clog2(MAXB + 1);

  frame_e          mode;
  logic            tick, line_raw, line;
  logic            nine, seven, par_on;
  logic [BW-1:0]   nbits;
  logic            done, perr, ferr;
  logic [MAXB-1:0] data;

  always_comb begin
    mode     = frame_e'(frame_mode_i);
    tick     = tick_sel_i ? tick_ext_i : tick_int_i;
    line_raw = (mode == FRM_LOOP) ? txd_loop_i : rxd_i;
    nine     = (mode == FRM_NINE) || (mode == FRM_LOOP);
    seven    = (mode == FRM_SEVEN);
    par_on   = par_en_i && !nine;
    unique case (mode)
      FRM_SEVEN: nbits = BW'(MAXB - 2);
      FRM_EIGHT: nbits = BW'(MAXB - 1);
      default:   nbits = BW'(MAXB);
    endcase
  end

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_raw),
    .q_o    (line)
  );

  uart_rx_framer #(.OVS(OVS), .MAXB(MAXB)) u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .line_i    (line),
    .nbits_i   (nbits),
    .par_on_i  (par_on),
    .par_sel_i (par_sel_i),
    .done_o    (done),
    .data_o    (data),
    .perr_o    (perr),
    .ferr_o    (ferr)
  );

  uart_rx_status #(.MAXB(MAXB)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .data_i     (data),
    .perr_i     (perr),
    .ferr_i     (ferr),
    .nine_i     (nine),
    .seven_i    (seven),
    .line_i     (line),
    .buf_rd_i   (buf_rd_i),
    .stat_rd_i  (stat_rd_i),
    .stat_wr_i  (stat_wr_i),
    .attn_wr_i  (stat_wdata_i[STAT_ATTN]),
    .irq_en_i   (irq_en_i),
    .rx_data_o  (rx_data_o),
    .buf_full_o (buf_full_o),
    .status_o   (status_o),
    .err_o      (err_o),
    .irq_o      (irq_o)
  );

  // R9: the interrupt request never rises while the enable is low
  p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  // R8: the global error flag never shows with all sticky flags clear
  p_err_needs_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($countones(status_o[2:0]) != 0));
endmodule

// File: tb/uart_rx_attn_tb.sv
module uart_rx_attn_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INT_DIV    = 4;
  localparam int EXT_DIV    = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_int = 1'b0, tick_ext = 1'b0, tick_sel = 1'b0;
  logic       rxd = 1'b1, txd_loop = 1'b1;
  logic [1:0] frame_mode = 2'b00;
  logic       par_en = 1'b0;
  logic [1:0] par_sel = 2'b00;
  logic       irq_en = 1'b0;
  logic       buf_rd = 1'b0, stat_rd = 1'b0, stat_wr = 1'b0;
  logic [7:0] stat_wdata = '0;
  logic [7:0] rx_data, status;
  logic       buf_full, err, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int icnt = 0, ecnt = 0;

  // expected state
  logic [7:0] e_data = '0;
  logic e_full = 0, e_pe = 0, e_fe = 0, e_doe = 0, e_attn = 0, e_b9 = 0, e_rcv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_attn u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_int_i(tick_int), .tick_ext_i(tick_ext),
    .tick_sel_i(tick_sel), .rxd_i(rxd), .txd_loop_i(txd_loop),
    .frame_mode_i(frame_mode), .par_en_i(par_en), .par_sel_i(par_sel),
    .irq_en_i(irq_en), .buf_rd_i(buf_rd), .stat_rd_i(stat_rd),
    .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata), .rx_data_o(rx_data),
    .buf_full_o(buf_full), .status_o(status), .err_o(err), .irq_o(irq)
  );

  always @(posedge clk) begin
    icnt     <= (icnt == INT_DIV-1) ? 0 : icnt + 1;
    ecnt     <= (ecnt == EXT_DIV-1) ? 0 : ecnt + 1;
    tick_int <= (icnt == INT_DIV-1);
    tick_ext <= (ecnt == EXT_DIV-1);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock relations for R8 and R9
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R9 irq", irq, irq_en & buf_full);
      check("R8 err", err, |status[2:0]);
    end
  end

  function automatic logic [7:0] e_status();
    return {2'b00, e_rcv, e_b9, e_attn, e_doe, e_fe, e_pe};
  endfunction

  task automatic check_all(input string req);
    check({req, " data"}, rx_data, e_data);
    check({req, " full"}, buf_full, e_full);
    check({req, " status"}, status, e_status());
  endtask

  task automatic model_char(input logic nine, input logic seven, input logic [8:0] d,
                            input logic pe, input logic fe);
    if (fe) e_rcv = 1;
    if (nine && e_attn && !d[8]) return;
    if (nine && d[8]) e_attn = 0;
    e_pe = e_pe | pe;
    e_fe = e_fe | fe;
    if (e_full) e_doe = 1;
    else begin
      e_full = 1;
      e_data = seven ? {1'b0, d[6:0]} : d[7:0];
      e_b9   = nine & d[8];
    end
  endtask

  task automatic put_bit(input logic b, input int div, input logic lp);
    if (lp) txd_loop = b; else rxd = b;
    repeat (16*div) @(negedge clk);
  endtask

  task automatic send(input int nb, input logic [8:0] d, input logic pen, input logic pbit,
                      input logic stopb, input int div, input logic lp);
    put_bit(1'b0, div, lp);
    for (int i = 0; i < nb; i++) put_bit(d[i], div, lp);
    if (pen) put_bit(pbit, div, lp);
    put_bit(stopb, div, lp);
    if (stopb) put_bit(1'b1, div, lp);
    repeat (8) @(negedge clk);
  endtask

  task automatic rd_buf();
    buf_rd = 1; @(negedge clk); buf_rd = 0; e_full = 0;
  endtask

  task automatic rd_stat();
    stat_rd = 1; @(negedge clk); stat_rd = 0; e_pe = 0; e_fe = 0; e_doe = 0;
  endtask

  task automatic wr_stat(input logic [7:0] v);
    stat_wdata = v; stat_wr = 1; @(negedge clk); stat_wr = 0; e_attn = v[3];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 full", buf_full, 0);
    check("R1 err", err, 0);
    check("R1 irq", irq, 0);
    check("R1 status", status, 0);
    check("R1 data", rx_data, 0);

    // R2 R3 eight-bit, no parity, irq enabled (R9)
    irq_en = 1;
    send(8, 9'h0A5, 0, 0, 1, INT_DIV, 0);
    model_char(0, 0, 9'h0A5, 0, 0);
    check_all("R2 R3 eight-bit");
    check("R9 irq on", irq, 1);
    rd_buf();
    check("R2 read clears", buf_full, 0);
    irq_en = 0;

    // R4 odd parity correct then wrong
    par_en = 1; par_sel = 2'b00;
    send(8, 9'h03C, 1, 1, 1, INT_DIV, 0);
    model_char(0, 0, 9'h03C, 0, 0);
    check_all("R4 odd ok");
    rd_buf();
    send(8, 9'h03C, 1, 0, 1, INT_DIV, 0);
    model_char(0, 0, 9'h03C, 1, 0);
    check_all("R4 odd bad");
    check("R8 err set", err, 1);
    // R5 writes do not touch error flags
    wr_stat(8'h07);
    check("R5 write ignored", status, e_status());
    rd_stat();
    check_all("R5 read clears");
    wr_stat(8'h00);
    rd_buf();

    // R4 even, mark
    par_sel = 2'b01;
    send(8, 9'h001, 1, 0, 1, INT_DIV, 0);
    model_char(0, 0, 9'h001, 1, 0);
    check_all("R4 even bad");
    rd_stat(); rd_buf();
    par_sel = 2'b10;
    send(8, 9'h0F0, 1, 1, 1, INT_DIV, 0);
    model_char(0, 0, 9'h0F0, 0, 0);
    check_all("R4 mark ok");
    rd_buf();
    par_sel = 2'b11;
    send(8, 9'h0F0, 1, 1, 1, INT_DIV, 0);
    model_char(0, 0, 9'h0F0, 1, 0);
    check_all("R4 space bad");
    rd_stat(); rd_buf();

    // R3 seven-bit with even parity
    frame_mode = 2'b01; par_sel = 2'b01;
    send(7, 9'h055, 1, 0, 1, INT_DIV, 0);
    model_char(0, 1, 9'h055, 0, 0);
    check_all("R3 seven-bit");
    // R6 overrun: second character while full
    send(7, 9'h07F, 1, 1, 1, INT_DIV, 0);
    model_char(0, 1, 9'h07F, 0, 0);
    check_all("R6 overrun keeps");
    rd_stat(); rd_buf();
    par_en = 0; frame_mode = 2'b00;

    // R7 framing error with held break, then release
    send(8, 9'h012, 0, 0, 0, INT_DIV, 0);
    model_char(0, 0, 9'h012, 0, 1);
    check_all("R7 framing");
    repeat (40) @(negedge clk);
    check("R7 break held", status[5], 1);
    rxd = 1;
    repeat (6) @(negedge clk);
    e_rcv = 0;
    check_all("R7 release");
    rd_stat(); rd_buf();

    // R13 nine-bit ninth bit
    frame_mode = 2'b10;
    send(9, 9'h1C3, 0, 0, 1, INT_DIV, 0);
    model_char(1, 0, 9'h1C3, 0, 0);
    check_all("R13 ninth bit");
    rd_buf();

    // R10 attention mode
    wr_stat(8'h08);
    check("R10 attn set", status[3], 1);
    send(9, 9'h044, 0, 0, 1, INT_DIV, 0);
    model_char(1, 0, 9'h044, 0, 0);
    check_all("R10 dropped");
    send(9, 9'h123, 0, 0, 1, INT_DIV, 0);
    model_char(1, 0, 9'h123, 0, 0);
    check_all("R10 address accepted");
    rd_buf();

    // R11 loopback ignores rxd
    frame_mode = 2'b11;
    repeat (4) @(negedge clk);
    rxd = 0;
    send(9, 9'h0B6, 0, 0, 1, INT_DIV, 1);
    model_char(1, 0, 9'h0B6, 0, 0);
    check_all("R11 loopback");
    rd_buf();
    frame_mode = 2'b00;
    rxd = 1;
    repeat (4) @(negedge clk);

    // R12 external tick source
    tick_sel = 1;
    send(8, 9'h069, 0, 0, 1, EXT_DIV, 0);
    model_char(0, 0, 9'h069, 0, 0);
    check_all("R12 external tick");
    rd_buf();

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule